// File: doc/BRIEF.md
# Parallel Port Transfer Mode Controller

This block holds the operating mode and data direction of an IEEE 1284 style parallel port. It also decides when the port's FIFO and its automatic strobe handshake are active, and it runs the DMA request and terminal-count service logic that moves data between host memory and that FIFO. Software talks to it over a small register bus. It programs a 3-bit mode, a direction bit, a DMA enable, a service-interrupt bit and a FIFO threshold. The FIFO itself lives elsewhere and reports its fill level to this block.

Mode changes follow a fixed rule. From the two software-driven base modes (000 and 001) the port may enter any mode. From every other mode it may only fall back to a base mode. The direction bit moves only while the port sits in mode 001. A DMA request is raised while the FIFO can accept or deliver at least a threshold's worth of bytes. A terminal count from the DMA engine sets the service-interrupt bit, which blocks further requests until software writes it back to zero. Software polls the FIFO empty and full flags before it leaves a transfer mode.

Top module: `ppm_ctrl`

## Requirements
- R1: The reset is synchronous and active high. After reset the mode is 000, the direction is forward (0), DMA enable is 0 and the service-interrupt bit is 1, so the control register reads 0x20. The threshold reads FIFO_DEPTH/2, and dma_req, irq, fifo_en and auto_hs are all 0.
- R2: The control register is at address 0, with mode in bits [2:0], direction in bit 3 (1 = reverse), DMA enable in bit 4 and service-interrupt in bit 5. While the current mode is 000 or 001, a control write loads any mode value.
- R3: While the current mode is neither 000 nor 001, a control write loads the mode only if the written value is 000 or 001. Any other written mode value leaves the mode unchanged.
- R4: A control write changes the direction bit only when the mode before the write is 001. In any other mode the direction is kept.
- R5: fifo_en and auto_hs are 1 exactly when the mode is 010 or 011. They are 0 in every other mode.
- R6: In the forward direction, dma_req is 1 when all of these hold: DMA enable is 1, service-interrupt is 0, the mode is 010 or 011, and the free space (FIFO_DEPTH minus fifo_level) is at or above the threshold. The threshold is written and read at address 1.
- R7: In the reverse direction, dma_req follows the same conditions as R6, except that fifo_level (not the free space) must be at or above the threshold.
- R8: When dma_tc is sampled high while service-interrupt is 0, service-interrupt reads 1 after that edge, irq is high for exactly one cycle, and dma_req drops. A dma_tc while service-interrupt is already 1 produces no irq.
- R9: Writing 0 to service-interrupt clears it and re-arms dma_req. If dma_tc arrives in the same cycle as that write, the bit ends up set.
- R10: fifo_empty is 1 when fifo_level is 0, and fifo_full is 1 when fifo_level equals FIFO_DEPTH. The status register is at address 2, with empty in bit 0, full in bit 1 and dma_req in bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| fifo_level | input | LVL_W | Bytes held in the FIFO |
| dma_tc | input | 1 | DMA terminal-count pulse |
| mode_o | output | 3 | Current mode |
| dir_o | output | 1 | Current direction (1 = reverse) |
| fifo_en | output | 1 | FIFO data movement enabled |
| auto_hs | output | 1 | Hardware handshake enabled |
| dma_req | output | 1 | DMA request |
| irq | output | 1 | One-cycle terminal-count interrupt |
| fifo_empty | output | 1 | FIFO holds no data |
| fifo_full | output | 1 | FIFO is full |

## Verification
The assertions assume that reset is held for at least one clock before any check counts, and that fifo_level never exceeds FIFO_DEPTH. The free-space arithmetic and the full flag are only meaningful inside that range. The stimulus drives fifo_level only with values from 0 to FIFO_DEPTH. It also changes all inputs on the falling edge, so every rising edge samples stable values for the write strobe, the terminal-count pulse and the level.

// File: rtl/ppm_pkg.sv
package ppm_pkg;

    typedef enum logic [2:0] {
        MODE_COMPAT   = 3'b000,
        MODE_BYTE     = 3'b001,
        MODE_FWD_FIFO = 3'b010,
        MODE_XFER     = 3'b011,
        MODE_RSV4     = 3'b100,
        MODE_RSV5     = 3'b101,
        MODE_TEST     = 3'b110,
        MODE_CFG      = 3'b111
    } ppm_mode_e;

    typedef struct packed {
        logic      svc;
        logic      dma_en;
        logic      dir;
        ppm_mode_e mode;
    } ppm_ctrl_t;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_THR  = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

    function automatic logic is_base(input ppm_mode_e m);
        return (m == MODE_COMPAT) || (m == MODE_BYTE);
    endfunction

    function automatic logic is_xfer(input ppm_mode_e m);
        return (m == MODE_FWD_FIFO) || (m == MODE_XFER);
    endfunction

    function automatic logic mode_allowed(input ppm_mode_e cur, input ppm_mode_e req);
        return is_base(cur) || is_base(req);
    endfunction

endpackage

// File: rtl/ppm_mode_reg.sv
module ppm_mode_reg
    import ppm_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_ctrl,
    input  ppm_mode_e req_mode,
    input  logic      req_dir,
    output ppm_mode_e mode_q,
    output logic      dir_q
);

    logic mode_ok;
    logic dir_ok;

    always_comb begin
        mode_ok = wr_ctrl && mode_allowed(mode_q, req_mode);
        dir_ok  = wr_ctrl && (mode_q == MODE_BYTE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_COMPAT;
            dir_q  <= 1'b0;
        end else begin
            if (mode_ok) mode_q <= req_mode;
            if (dir_ok)  dir_q  <= req_dir;
        end
    end

endmodule

// File: rtl/ppm_dma_ctl.sv
module ppm_dma_ctl #(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ctrl,
    input  logic             wr_dma_en,
    input  logic             wr_svc,
    input  logic             wr_thr,
    input  logic [LVL_W-1:0] thr_wdata,
    input  logic             dma_tc,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dir,
    input  logic             xfer,
    output logic             dma_req,
    output logic             irq,
    output logic             svc_q,
    output logic             dma_en_q,
    output logic [LVL_W-1:0] thr_q
);

    localparam logic [LVL_W-1:0] DEPTH_V = LVL_W'(FIFO_DEPTH);
    localparam logic [LVL_W-1:0] THR_RST = LVL_W'(FIFO_DEPTH / 2);

    logic [LVL_W-1:0] free_space;
    logic [LVL_W-1:0] avail;
    logic             tc_hit;

    always_comb begin
        free_space = DEPTH_V - fifo_level;
        avail      = dir ? fifo_level : free_space;
        tc_hit     = dma_tc && !svc_q;
        dma_req    = dma_en_q && !svc_q && xfer && (avail >= thr_q);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q    <= 1'b1;
            dma_en_q <= 1'b0;
            thr_q    <= THR_RST;
            irq      <= 1'b0;
        end else begin
            irq <= tc_hit;
            if (wr_ctrl) dma_en_q <= wr_dma_en;
            if (dma_tc)       svc_q <= 1'b1;
            else if (wr_ctrl) svc_q <= wr_svc;
            if (wr_thr) thr_q <= thr_wdata;
        end
    end

endmodule

// File: rtl/ppm_ctrl.sv
module ppm_ctrl
    import ppm_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [7:0]       wdata,
    output logic [7:0]       rdata,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dma_tc,
    output logic [2:0]       mode_o,
    output logic             dir_o,
    output logic             fifo_en,
    output logic             auto_hs,
    output logic             dma_req,
    output logic             irq,
    output logic             fifo_empty,
    output logic             fifo_full
);

    ppm_ctrl_t        wr_fields;
    ppm_ctrl_t        cur;
    ppm_mode_e        mode_q;
    logic             dir_q;
    logic             svc_q;
    logic             dma_en_q;
    logic [LVL_W-1:0] thr_q;
    logic             wr_ctrl;
    logic             wr_thr;
    logic             xfer;

    always_comb begin
        wr_fields = ppm_ctrl_t'(wdata[5:0]);
        wr_ctrl   = wr_en && (addr == ADDR_CTRL);
        wr_thr    = wr_en && (addr == ADDR_THR);
        xfer      = is_xfer(mode_q);
    end

    ppm_mode_reg u_mode (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .req_mode(wr_fields.mode),
        .req_dir (wr_fields.dir),
        .mode_q  (mode_q),
        .dir_q   (dir_q)
    );

    ppm_dma_ctl #(.FIFO_DEPTH(FIFO_DEPTH)) u_dma (
        .clk       (clk),
        .rst       (rst),
        .wr_ctrl   (wr_ctrl),
        .wr_dma_en (wr_fields.dma_en),
        .wr_svc    (wr_fields.svc),
        .wr_thr    (wr_thr),
        .thr_wdata (wdata[LVL_W-1:0]),
        .dma_tc    (dma_tc),
        .fifo_level(fifo_level),
        .dir       (dir_q),
        .xfer      (xfer),
        .dma_req   (dma_req),
        .irq       (irq),
        .svc_q     (svc_q),
        .dma_en_q  (dma_en_q),
        .thr_q     (thr_q)
    );

    always_comb begin
        cur.svc    = svc_q;
        cur.dma_en = dma_en_q;
        cur.dir    = dir_q;
        cur.mode   = mode_q;
        mode_o     = mode_q;
        dir_o      = dir_q;
        fifo_en    = xfer;
        auto_hs    = xfer;
        fifo_empty = (fifo_level == '0);
        fifo_full  = (fifo_level == LVL_W'(FIFO_DEPTH));
        case (addr)
            ADDR_CTRL: rdata = {2'b00, cur};
            ADDR_THR:  rdata = 8'(thr_q);
            ADDR_STAT: rdata = {5'b0, dma_req, fifo_full, fifo_empty};
            default:   rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/ppm_ctrl_chk.sv
module ppm_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic [2:0] mode_o,
    input logic       dir_o,
    input logic       fifo_en,
    input logic       auto_hs,
    input logic       dma_req,
    input logic       irq
);

    // R3: leaving a non-base mode lands only in 000 or 001
    p_exit_to_base_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_o) > 3'd1) |-> (mode_o <= 3'd1 || mode_o == $past(mode_o)));

    // R4: direction moves only out of mode 001
    p_dir_gate_r4: assert property (@(posedge clk) disable iff (rst)
        (dir_o != $past(dir_o)) |-> ($past(mode_o) == 3'd1));

    // R5: base modes never enable FIFO or handshake
    p_base_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        (mode_o <= 3'd1) |-> (!fifo_en && !auto_hs));

    // R6: a request needs an active transfer mode
    p_req_needs_xfer_r6: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> fifo_en);

    // R8: interrupt is a single-cycle pulse
    p_irq_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R8: request is blocked once terminal count was serviced
    p_irq_blocks_req_r8: assert property (@(posedge clk) disable iff (rst)
        irq |-> !dma_req);

endmodule

bind ppm_ctrl ppm_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .mode_o (mode_o),
    .dir_o  (dir_o),
    .fifo_en(fifo_en),
    .auto_hs(auto_hs),
    .dma_req(dma_req),
    .irq    (irq)
);

// File: tb/ppm_ctrl_test.sv
module ppm_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 16;
    localparam int LW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic        wr;
        logic [1:0]  ad;
        logic [7:0]  wd;
        logic [4:0]  lvl;
        logic [2:0]  emode;
        logic        edir;
        logic        ereq;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 2'd0, 8'h29, 5'd0,  3'd1, 1'b0, 1'b0}, // R2 R4 dir held in 000
        '{1'b1, 2'd0, 8'h29, 5'd0,  3'd1, 1'b1, 1'b0}, // R4 dir moves in 001
        '{1'b1, 2'd0, 8'h1B, 5'd4,  3'd3, 1'b1, 1'b0}, // R2 R7 below thr
        '{1'b0, 2'd0, 8'h00, 5'd8,  3'd3, 1'b1, 1'b1}, // R7 at thr
        '{1'b1, 2'd0, 8'h12, 5'd8,  3'd3, 1'b1, 1'b1}, // R3 R4 ignored
        '{1'b1, 2'd1, 8'h09, 5'd8,  3'd3, 1'b1, 1'b0}, // R7 thr raised
        '{1'b1, 2'd0, 8'h10, 5'd8,  3'd0, 1'b1, 1'b0}, // R3 R4 back to base
        '{1'b1, 2'd0, 8'h11, 5'd8,  3'd1, 1'b1, 1'b0}, // R4
        '{1'b1, 2'd0, 8'h11, 5'd8,  3'd1, 1'b0, 1'b0}, // R4
        '{1'b1, 2'd0, 8'h12, 5'd8,  3'd2, 1'b0, 1'b0}, // R6 free 8 < 9
        '{1'b0, 2'd0, 8'h00, 5'd7,  3'd2, 1'b0, 1'b1}, // R6 free 9
        '{1'b1, 2'd0, 8'h17, 5'd7,  3'd2, 1'b0, 1'b1}, // R3 111 ignored
        '{1'b1, 2'd0, 8'h00, 5'd7,  3'd0, 1'b0, 1'b0}, // R3 exit
        '{1'b1, 2'd0, 8'h05, 5'd0,  3'd5, 1'b0, 1'b0}, // R2 any mode
        '{1'b1, 2'd0, 8'h03, 5'd0,  3'd5, 1'b0, 1'b0}, // R3 011 refused
        '{1'b1, 2'd0, 8'h01, 5'd0,  3'd1, 1'b0, 1'b0}  // R3 back to 001
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    addr = 2'd0;
    logic [7:0]    wdata = 8'h00;
    logic [7:0]    rdata;
    logic [LW-1:0] fifo_level = '0;
    logic          dma_tc = 1'b0;
    logic [2:0]    mode_o;
    logic          dir_o, fifo_en, auto_hs, dma_req, irq, fifo_empty, fifo_full;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ppm_ctrl #(.FIFO_DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .fifo_level(fifo_level), .dma_tc(dma_tc),
        .mode_o(mode_o), .dir_o(dir_o), .fifo_en(fifo_en), .auto_hs(auto_hs),
        .dma_req(dma_req), .irq(irq), .fifo_empty(fifo_empty), .fifo_full(fifo_full)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FIFO? no: FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        step();
        wr_en = 1'b0; addr = 2'd0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        repeat (3) step();
        rst = 1'b0;
        // R1 reset state
        addr = 2'd0;
        #1 chk("R1 ctrl", rdata, 8'h20);
        chk("R1 mode", {5'b0, mode_o}, 8'h00);
        chk("R1 en", {6'b0, fifo_en, auto_hs}, 8'h00);
        chk("R1 req_irq", {6'b0, dma_req, irq}, 8'h00);
        addr = 2'd1;
        #1 chk("R1 thr", rdata, 8'(DEPTH / 2));
        addr = 2'd2;
        #1 chk("R10 status empty", rdata, 8'h01);
        addr = 2'd0;

        for (int i = 0; i < NV; i++) begin
            wr_en = VEC[i].wr; addr = VEC[i].ad; wdata = VEC[i].wd;
            fifo_level = VEC[i].lvl;
            step();
            wr_en = 1'b0;
            chk($sformatf("R2 R3 mode v%0d", i), {5'b0, mode_o}, {5'b0, VEC[i].emode});
            chk($sformatf("R4 dir v%0d", i), {7'b0, dir_o}, {7'b0, VEC[i].edir});
            chk($sformatf("R6 R7 req v%0d", i), {7'b0, dma_req}, {7'b0, VEC[i].ereq});
            chk($sformatf("R5 en v%0d", i), {6'b0, fifo_en, auto_hs},
                (VEC[i].emode == 3'd2 || VEC[i].emode == 3'd3) ? 8'h03 : 8'h00);
        end

        // R8 terminal count: mode 011 forward, dma on, svc 0, thr 4
        fifo_level = '0;
        wr(2'd0, 8'h13);
        wr(2'd1, 8'h04);
        chk("R6 req before tc", {7'b0, dma_req}, 8'h01);
        dma_tc = 1'b1;
        step();
        dma_tc = 1'b0;
        chk("R8 irq", {7'b0, irq}, 8'h01);
        chk("R8 req off", {7'b0, dma_req}, 8'h00);
        addr = 2'd0;
        #1 chk("R8 svc set", rdata, 8'h33);
        step();
        chk("R8 irq one cycle", {7'b0, irq}, 8'h00);
        dma_tc = 1'b1;
        step();
        dma_tc = 1'b0;
        chk("R8 no irq when svc set", {7'b0, irq}, 8'h00);

        // R9 re-arm, then collision
        wr(2'd0, 8'h13);
        chk("R9 rearm", {7'b0, dma_req}, 8'h01);
        dma_tc = 1'b1;
        wr(2'd0, 8'h13);
        dma_tc = 1'b0;
        #1 chk("R9 tc wins", rdata, 8'h33);
        chk("R9 irq on collision", {7'b0, irq}, 8'h01);

        // R10 full flag, forward free 0
        wr(2'd0, 8'h13);
        fifo_level = LW'(DEPTH);
        addr = 2'd2;
        #1 chk("R10 status full", rdata, 8'h02);
        chk("R10 flags", {6'b0, fifo_full, fifo_empty}, 8'h02);
        fifo_level = LW'(5);
        #1 chk("R10 status mid", rdata, 8'h04);

        // R1 reset again restores state
        rst = 1'b1;
        step();
        rst = 1'b0;
        addr = 2'd0;
        #1 chk("R1 reset reapplied", rdata, 8'h20);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule